// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns a 32-bit internal byte address into the narrow multiplexed address that a DRAM array expects. The array is eight bytes wide, so the three lowest byte-address bits select a byte lane and never reach the DRAM pins. A select input from the memory controller chooses whether the bus shows the row half or the column half of the word address.

A geometry input tells the block whether the attached parts use nine or ten column address bits. The split between the column field and the row field moves with that input. The block also drives a second copy of address bit 0 for modules that need the extra load.

Both outputs come from registers. Any change on the inputs reaches the pins on the clock edge after it is sampled.

Top module: `dram_addr_mux`

## Requirements
- R1: While the synchronous active-high reset is asserted at a clock edge, the bus and its duplicate bit are zero after that edge.
- R2: With the row select high and the nine-column geometry input high, the bus shows byte address bits [23:12] after the next edge.
- R3: With the row select high and the nine-column geometry input low (ten-column), the bus shows byte address bits [24:13] after the next edge.
- R4: With the row select low and the nine-column geometry input high, the bus shows byte address bits [11:3] in its bits [8:0], with bits [11:9] zero.
- R5: With the row select low and the nine-column geometry input low, the bus shows byte address bits [12:3] in its bits [9:0], with bits [11:10] zero.
- R6: The duplicate output always equals bit 0 of the bus.
- R7: Byte address bits [2:0] have no effect on the bus in any mode.
- R8: The bus changes only at a clock edge, one cycle after the inputs are sampled. A change of select or geometry between edges leaves the bus unchanged until the next edge.
- R9: Byte address bits [31:25] have no effect on the bus in either geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_addr | input | 32 | Internal byte address |
| row_sel | input | 1 | High selects the row field, low selects the column field |
| col9_mode | input | 1 | High: nine column bits; low: ten column bits |
| dram_addr | output | 12 | Registered multiplexed DRAM address |
| dram_addr0_dup | output | 1 | Registered copy of dram_addr bit 0 |

## Verification
The bench applies addresses with distinct bit patterns at the nine/ten boundary, bits 12 and 24 in particular. A design that split the fields at the wrong position would show a shifted or overlapping row or column. It sets the byte-lane bits and the top seven bits to opposite values and expects the same bus. A design that used the wrong offset would leak those bits onto the pins. Select and geometry are changed between edges to expose a combinational path or an extra pipeline stage. The duplicate pin is compared on every vector to catch a copy taken from the wrong bit or the wrong stage.

// File: rtl/dram_addr_pkg.sv
package dram_addr_pkg;

    parameter int ADDR_W   = 32;
    parameter int DA_W     = 12;
    parameter int LANE_W   = 3;
    parameter int COL_MIN  = 9;
    parameter int COL_MAX  = 10;
    localparam int NUM_GEOM = COL_MAX - COL_MIN + 1;

    typedef enum logic {
        GEOM_COL10 = 1'b0,
        GEOM_COL9  = 1'b1
    } geom_e;

    typedef struct packed {
        logic [DA_W-1:0] row;
        logic [DA_W-1:0] col;
    } rc_pair_t;

    function automatic logic [DA_W-1:0] col_of(input logic [ADDR_W-1:0] a, input int cbits);
        logic [ADDR_W-1:0] w;
        logic [ADDR_W-1:0] mask;
        w    = a >> LANE_W;
        mask = (ADDR_W'(1) << cbits) - ADDR_W'(1);
        return DA_W'(w & mask);
    endfunction

    function automatic logic [DA_W-1:0] row_of(input logic [ADDR_W-1:0] a, input int cbits);
        logic [ADDR_W-1:0] w;
        w = a >> (LANE_W + cbits);
        return DA_W'(w);
    endfunction

    function automatic int geom_index(input geom_e g);
        return (g == GEOM_COL9) ? (9 - COL_MIN) : (10 - COL_MIN);
    endfunction

endpackage

// File: rtl/dram_addr_format.sv
module dram_addr_format
    import dram_addr_pkg::*;
(
    input  logic [ADDR_W-1:0] byte_addr,
    output rc_pair_t          pairs [NUM_GEOM]
);
    for (genvar g = 0; g < NUM_GEOM; g++) begin : g_geom
        localparam int CBITS = COL_MIN + g;
        always_comb begin
            pairs[g].col = col_of(byte_addr, CBITS);
            pairs[g].row = row_of(byte_addr, CBITS);
        end
    end
endmodule

// File: rtl/dram_addr_select.sv
module dram_addr_select
    import dram_addr_pkg::*;
(
    input  rc_pair_t        pairs [NUM_GEOM],
    input  geom_e           geom,
    input  logic            row_sel,
    output logic [DA_W-1:0] next_addr
);
    rc_pair_t chosen;
    always_comb begin
        chosen    = pairs[geom_index(geom)];
        next_addr = row_sel ? chosen.row : chosen.col;
    end
endmodule

// File: rtl/dram_addr_reg.sv
module dram_addr_reg
    import dram_addr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [DA_W-1:0] next_addr,
    output logic [DA_W-1:0] q_addr,
    output logic            q_dup
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_addr <= '0;
            q_dup  <= 1'b0;
        end else begin
            q_addr <= next_addr;
            q_dup  <= next_addr[0];
        end
    end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] byte_addr,
    input  logic        row_sel,
    input  logic        col9_mode,
    output logic [11:0] dram_addr,
    output logic        dram_addr0_dup
);
    rc_pair_t        pairs [NUM_GEOM];
    logic [DA_W-1:0] next_addr;
    geom_e           geom;

    assign geom = col9_mode ? GEOM_COL9 : GEOM_COL10;

    dram_addr_format u_format (
        .byte_addr (byte_addr),
        .pairs     (pairs)
    );

    dram_addr_select u_select (
        .pairs     (pairs),
        .geom      (geom),
        .row_sel   (row_sel),
        .next_addr (next_addr)
    );

    dram_addr_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .next_addr (next_addr),
        .q_addr    (dram_addr),
        .q_dup     (dram_addr0_dup)
    );
endmodule

// File: rtl/dram_addr_mux_checker.sv
module dram_addr_mux_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] byte_addr,
    input logic        row_sel,
    input logic        col9_mode,
    input logic [11:0] dram_addr,
    input logic        dram_addr0_dup
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_zero_R1: assert (dram_addr == 12'd0 && dram_addr0_dup == 1'b0)
                else $error("reset state not zero");
        end
    end

    assert_row_col9_R2: assert property (@(posedge clk) disable iff (rst)
        (row_sel && col9_mode) |=> (dram_addr == $past(byte_addr[23:12])));

    assert_row_col10_R3: assert property (@(posedge clk) disable iff (rst)
        (row_sel && !col9_mode) |=> (dram_addr == $past(byte_addr[24:13])));

    assert_col_col9_R4: assert property (@(posedge clk) disable iff (rst)
        (!row_sel && col9_mode) |=> (dram_addr == {3'b000, $past(byte_addr[11:3])}));

    assert_col_col10_R5: assert property (@(posedge clk) disable iff (rst)
        (!row_sel && !col9_mode) |=> (dram_addr == {2'b00, $past(byte_addr[12:3])}));

    assert_dup_match_R6: assert property (@(posedge clk) disable iff (rst)
        (dram_addr0_dup == dram_addr[0]));
endmodule

bind dram_addr_mux dram_addr_mux_checker u_checker (
    .clk            (clk),
    .rst            (rst),
    .byte_addr      (byte_addr),
    .row_sel        (row_sel),
    .col9_mode      (col9_mode),
    .dram_addr      (dram_addr),
    .dram_addr0_dup (dram_addr0_dup)
);

// File: tb/dram_addr_mux_bench.sv
module dram_addr_mux_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] byte_addr = '0;
    logic        row_sel = 1'b0;
    logic        col9_mode = 1'b0;
    logic [11:0] dram_addr;
    logic        dram_addr0_dup;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dram_addr_mux u_dram_addr_mux (
        .clk            (clk),
        .rst            (rst),
        .byte_addr      (byte_addr),
        .row_sel        (row_sel),
        .col9_mode      (col9_mode),
        .dram_addr      (dram_addr),
        .dram_addr0_dup (dram_addr0_dup)
    );

    function automatic logic [11:0] model(input logic [31:0] a, input logic rs, input logic m9);
        if (rs) return m9 ? a[23:12] : a[24:13];
        return m9 ? {3'b000, a[11:3]} : {2'b00, a[12:3]};
    endfunction

    task automatic check(input string req, input logic [11:0] exp);
        vectors++;
        if (dram_addr !== exp || dram_addr0_dup !== exp[0]) begin
            misses++;
            $display("FAIL %s: addr=%h dup=%b expected addr=%h dup=%b",
                     req, dram_addr, dram_addr0_dup, exp, exp[0]);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic rs, input logic m9);
        byte_addr = a; row_sel = rs; col9_mode = m9;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        apply(32'hFFFF_FFFF, 1'b1, 1'b1);
        check("R1", 12'h000);
        apply(32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R1", 12'h000);
        rst = 1'b0;
    endtask

    task automatic t_row9();
        logic [31:0] v [3] = '{32'h00AB_C000, 32'h0080_1000, 32'h0055_5555};
        foreach (v[i]) begin
            apply(v[i], 1'b1, 1'b1);
            check("R2", model(v[i], 1'b1, 1'b1));
        end
    endtask

    task automatic t_row10();
        logic [31:0] v [3] = '{32'h0100_2000, 32'h01FF_E000, 32'h00AA_AAAA};
        foreach (v[i]) begin
            apply(v[i], 1'b1, 1'b0);
            check("R3", model(v[i], 1'b1, 1'b0));
        end
    endtask

    task automatic t_col9();
        logic [31:0] v [3] = '{32'h0000_0FF8, 32'h0000_1008, 32'h0000_0AA8};
        foreach (v[i]) begin
            apply(v[i], 1'b0, 1'b1);
            check("R4", model(v[i], 1'b0, 1'b1));
        end
    endtask

    task automatic t_col10();
        logic [31:0] v [3] = '{32'h0000_1FF8, 32'h0000_1008, 32'h0000_2008};
        foreach (v[i]) begin
            apply(v[i], 1'b0, 1'b0);
            check("R5", model(v[i], 1'b0, 1'b0));
        end
    endtask

    task automatic t_dup();
        apply(32'h0000_0008, 1'b0, 1'b1);
        check("R6", 12'h001);
        apply(32'h0000_1000, 1'b1, 1'b1);
        check("R6", 12'h001);
        apply(32'h0000_0010, 1'b0, 1'b0);
        check("R6", 12'h002);
    endtask

    task automatic t_lane_bits();
        for (int m = 0; m < 4; m++) begin
            apply(32'h0123_4567, m[1], m[0]);
            check("R7", model(32'h0123_4560, m[1], m[0]));
            apply(32'h0123_4560, m[1], m[0]);
            check("R7", model(32'h0123_4567, m[1], m[0]));
        end
    endtask

    task automatic t_high_bits();
        for (int m = 0; m < 4; m++) begin
            apply(32'hFE12_3458, m[1], m[0]);
            check("R9", model(32'h0012_3458, m[1], m[0]));
        end
    endtask

    task automatic t_latency();
        apply(32'h00AB_CDE8, 1'b1, 1'b1);
        check("R8", 12'hABC);
        row_sel = 1'b0; col9_mode = 1'b0;
        #1;
        check("R8", 12'hABC);
        @(posedge clk); #1;
        check("R8", model(32'h00AB_CDE8, 1'b0, 1'b0));
        col9_mode = 1'b1;
        #1;
        check("R8", model(32'h00AB_CDE8, 1'b0, 1'b0));
        @(posedge clk); #1;
        check("R8", model(32'h00AB_CDE8, 1'b0, 1'b1));
    endtask

    initial begin
        t_reset();
        t_row9();
        t_row10();
        t_col9();
        t_col10();
        t_dup();
        t_lane_bits();
        t_high_bits();
        t_latency();
        t_reset();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            if (done) break;
            @(posedge clk);
        end
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule